// File: doc/BRIEF.md
# Banked Flash Address Decoder with Boot Remap

This block turns a 24-bit byte address into a flash hit flag, a bank index and a word line index for a 128 KB on-chip flash. The flash is seen through two address windows. A 32 KB low window holds the start of the flash. An upper window at 018000h to 02FFFFh holds the remaining 96 KB. The low window answers in segment 0 after reset, at 000000h to 007FFFh. An initialization step can move it to segment 1, at 010000h to 017FFFh. Boot vectors can then come from external memory while shared code stays in flash.

The flash is split into four banks that can be erased separately. The banks have unequal sizes: 48 KB, 48 KB, 24 KB and 8 KB. The banks are not contiguous in the address map. Bank 0 is made of the relocatable 32 KB low window plus the first 16 KB of the upper window. The array is 32 bits wide, so the decoder reports a line index that points to one double word.

The map is held by a two-state controller, `MAP_BOOT` and `MAP_REMAP`. Reset puts it in `MAP_BOOT`.
- Transition `to_remap` (`MAP_BOOT` to `MAP_REMAP`) happens when `init_wr` is high with `init_remap` at 1.
- Transition `to_boot` (`MAP_REMAP` to `MAP_BOOT`) happens when `init_wr` is high with `init_remap` at 0.
- Both transitions are blocked while `init_done` is high. In that case the controller stays in its current state (`hold`).

The address decode is combinational. Its result is registered on a valid strobe.

Top module: `flash_addr_map`

## Requirements
- R1: While reset is active and after it is released, the map is in the boot state. `res_vld`, `res_hit`, `res_bank` and `res_line` are all 0.
- R2: In the boot map, a strobed address from 000000h to 007FFFh hits with bank 0 and line = address >> 2.
- R3: In either map, a strobed address from 018000h to 02FFFFh hits with line = (address - 010000h) >> 2, a 15-bit value.
- R4: The bank comes from the flash-linear offset L, which is the line index times 4. The bank is 0 for L below C000h, 1 for L below 18000h, 2 for L below 1E000h, and 3 otherwise. Bank 0 therefore spans both windows.
- R5: In the remap map, an address from 010000h to 017FFFh hits with bank 0 and line = (address - 010000h) >> 2. Addresses 000000h to 007FFFh miss.
- R6: In the boot map, addresses 010000h to 017FFFh miss. In both maps, 008000h to 00FFFFh and 030000h and above miss.
- R7: A miss gives `res_hit` = 0, `res_bank` = 0 and `res_line` = 0.
- R8: The result of a strobe appears exactly one clock after `addr_vld` is sampled high. `res_vld` is high only in that cycle. The result outputs hold their value while no strobe arrives.
- R9: A write pulse on `init_wr` while `init_done` is low loads `init_remap` into the map. The new map applies to strobes in later cycles, and writing 0 restores the boot map.
- R10: While `init_done` is high, `init_wr` has no effect on the map.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_wr | input | 1 | Write pulse for the map control |
| init_remap | input | 1 | Map value to load: 1 selects the segment 1 low window |
| init_done | input | 1 | High locks the map control |
| addr_vld | input | 1 | Address strobe |
| addr | input | 24 | Byte address to decode |
| res_vld | output | 1 | Result valid, one cycle after the strobe |
| res_hit | output | 1 | Address falls in an active flash window |
| res_bank | output | 2 | Bank index, 0 to 3 |
| res_line | output | 15 | Double-word line index within the flash |

## Verification
The hardest situation to reach from the ports is a map change that must be seen, or must be refused, on the very next strobe. The map state itself is not visible at the ports. So the stimulus writes the control and then probes the address 000000h and the segment 1 low window right away. The hit or miss on those probes shows which state the controller holds. The same probes are repeated with `init_done` high to show that a write was refused. After that, the lock is released and the boot map is restored, which shows the `to_boot` transition. Each map state is followed by a sweep of every window edge and bank edge, plus the bytes on both sides of each.

// File: rtl/flash_map_pkg.sv
package flash_map_pkg;
    localparam int ADDR_W      = 24;
    localparam int NBANK       = 4;
    localparam int BANK_W      = $clog2(NBANK);
    localparam int FLASH_BYTES = 128 * 1024;
    localparam int LIN_W       = $clog2(FLASH_BYTES);
    localparam int WORD_BYTES  = 4;
    localparam int LINE_W      = LIN_W - $clog2(WORD_BYTES);
    localparam int LOW_BYTES   = 32 * 1024;

    localparam logic [ADDR_W-1:0] BOOT_BASE  = 24'h000000;
    localparam logic [ADDR_W-1:0] REMAP_BASE = 24'h010000;
    localparam logic [ADDR_W-1:0] UPPER_BASE = REMAP_BASE + ADDR_W'(LOW_BYTES);
    localparam logic [ADDR_W-1:0] UPPER_END  = REMAP_BASE + ADDR_W'(FLASH_BYTES);

    localparam int BANK_KB [NBANK] = '{48, 48, 24, 8};

    function automatic int bank_start(input int b);
        int s;
        s = 0;
        for (int j = 0; j < b; j++) s += BANK_KB[j] * 1024;
        return s;
    endfunction

    typedef enum logic {MAP_BOOT = 1'b0, MAP_REMAP = 1'b1} map_e;

    typedef struct packed {
        logic              hit;
        logic [BANK_W-1:0] bank;
        logic [LINE_W-1:0] line;
    } dec_t;
endpackage

// File: rtl/flash_remap_ctl.sv
module flash_remap_ctl
    import flash_map_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic wr_val,
    input  logic lock,
    output logic remap
);
    map_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MAP_BOOT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MAP_BOOT:  if (wr && !lock && wr_val)  state_d = MAP_REMAP;
            MAP_REMAP: if (wr && !lock && !wr_val) state_d = MAP_BOOT;
            default:   state_d = MAP_BOOT;
        endcase
    end

    always_comb begin
        unique case (state_q)
            MAP_REMAP: remap = 1'b1;
            default:   remap = 1'b0;
        endcase
    end
endmodule

// File: rtl/flash_window_dec.sv
module flash_window_dec
    import flash_map_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              remap,
    output dec_t              dec
);
    localparam int LOW_W = $clog2(LOW_BYTES);

    logic              in_low, in_up;
    logic [ADDR_W-1:0] low_base, rel;
    logic [LIN_W-1:0]  lin;
    logic [NBANK-1:1]  past_start;
    logic [BANK_W-1:0] bank_idx;

    always_comb begin
        low_base = remap ? REMAP_BASE : BOOT_BASE;
        in_low   = (addr[ADDR_W-1:LOW_W] == low_base[ADDR_W-1:LOW_W]);
        in_up    = (addr >= UPPER_BASE) && (addr < UPPER_END);
        rel      = in_low ? (addr - low_base) : (addr - REMAP_BASE);
        lin      = rel[LIN_W-1:0];
    end

    for (genvar b = 1; b < NBANK; b++) begin : g_edge
        assign past_start[b] = (lin >= LIN_W'(bank_start(b)));
    end

    always_comb begin
        bank_idx = '0;
        for (int b = 1; b < NBANK; b++)
            if (past_start[b]) bank_idx = BANK_W'(b);
    end

    always_comb begin
        if (in_low || in_up) begin
            dec.hit  = 1'b1;
            dec.bank = bank_idx;
            dec.line = lin[LIN_W-1:LIN_W-LINE_W];
        end else begin
            dec = '0;
        end
    end
endmodule

// File: rtl/flash_dec_reg.sv
module flash_dec_reg
    import flash_map_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic vld_in,
    input  dec_t dec_in,
    output logic vld_out,
    output dec_t dec_out
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_out <= 1'b0;
            dec_out <= '0;
        end else begin
            vld_out <= vld_in;
            if (vld_in) dec_out <= dec_in;
        end
    end
endmodule

// File: rtl/flash_addr_map.sv
module flash_addr_map
    import flash_map_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_wr,
    input  logic              init_remap,
    input  logic              init_done,
    input  logic              addr_vld,
    input  logic [23:0]       addr,
    output logic              res_vld,
    output logic              res_hit,
    output logic [1:0]        res_bank,
    output logic [14:0]       res_line
);
    logic remap_on;
    dec_t dec_c, dec_q;

    flash_remap_ctl u_ctl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (init_wr),
        .wr_val (init_remap),
        .lock   (init_done),
        .remap  (remap_on)
    );

    flash_window_dec u_dec (
        .addr  (addr),
        .remap (remap_on),
        .dec   (dec_c)
    );

    flash_dec_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .vld_in  (addr_vld),
        .dec_in  (dec_c),
        .vld_out (res_vld),
        .dec_out (dec_q)
    );

    assign res_hit  = dec_q.hit;
    assign res_bank = dec_q.bank;
    assign res_line = dec_q.line;
endmodule

// File: rtl/flash_addr_map_chk.sv
module flash_addr_map_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        addr_vld,
    input logic        init_done,
    input logic        remap_on,
    input logic        res_vld,
    input logic        res_hit,
    input logic [1:0]  res_bank,
    input logic [14:0] res_line
);
    assert_vld_next_R8: assert property (@(posedge clk) disable iff (!rst_n)
        addr_vld |=> res_vld);
    assert_no_vld_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_vld |=> !res_vld);
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_vld |=> ($stable(res_hit) && $stable(res_bank) && $stable(res_line)));
    assert_miss_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && !res_hit) |-> (res_bank == 2'd0 && res_line == 15'd0));
    assert_lock_R10: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> $stable(remap_on));
    assert_top_bank_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && res_hit && res_bank == 2'd3) |-> (res_line >= 15'h7800));
endmodule

bind flash_addr_map flash_addr_map_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_vld  (addr_vld),
    .init_done (init_done),
    .remap_on  (remap_on),
    .res_vld   (res_vld),
    .res_hit   (res_hit),
    .res_bank  (res_bank),
    .res_line  (res_line)
);

// File: tb/sim_flash_addr_map.sv
module sim_flash_addr_map;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        init_wr = 1'b0, init_remap = 1'b0, init_done = 1'b0;
    logic        addr_vld = 1'b0;
    logic [23:0] addr = '0;
    logic        res_vld, res_hit;
    logic [1:0]  res_bank;
    logic [14:0] res_line;

    int checks = 0;
    int errors = 0;
    bit model_remap = 1'b0;
    bit finished = 1'b0;

    logic [17:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_addr_map u0 (.*);

    function automatic logic [17:0] model(input int a, input bit rm);
        int lin;
        int bk;
        lin = -1;
        if (!rm && a < 'h8000) lin = a;
        else if (rm && a >= 'h10000 && a < 'h18000) lin = a - 'h10000;
        else if (a >= 'h18000 && a < 'h30000) lin = a - 'h10000;
        if (lin < 0) return 18'd0;
        bk = (lin < 'hC000) ? 0 : (lin < 'h18000) ? 1 : (lin < 'h1E000) ? 2 : 3;
        return {1'b1, 2'(bk), 15'(lin >> 2)};
    endfunction

    function automatic string tag_for(input int a, input bit rm);
        logic [17:0] e;
        e = model(a, rm);
        if (!e[17]) return "R6 R7";
        if (a < 'h8000) return "R2";
        if (a < 'h18000) return "R5";
        return "R3 R4";
    endfunction

    task automatic check(input string tag, input logic [17:0] act, input logic [17:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic probe(input int a, input string tag);
        @(negedge clk);
        addr     = 24'(a);
        addr_vld = 1'b1;
        exp_q.push_back(model(a, model_remap));
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        addr_vld = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic write_map(input bit v);
        @(negedge clk);
        addr_vld   = 1'b0;
        init_wr    = 1'b1;
        init_remap = v;
        if (!init_done) model_remap = v;
        @(negedge clk);
        init_wr = 1'b0;
    endtask

    task automatic sweep();
        int pts[19] = '{'h0, 'h3, 'h4, 'h7FFC, 'h7FFF, 'h8000, 'hFFFF, 'h10000, 'h17FFF,
                        'h18000, 'h1BFFF, 'h1C000, 'h27FFF, 'h28000, 'h2DFFF, 'h2E000,
                        'h2FFFF, 'h30000, 'hFFFFFF};
        foreach (pts[i]) probe(pts[i], tag_for(pts[i], model_remap));
        idle(3);
    endtask

    // monitor: pops expected items as results appear
    always @(negedge clk) begin
        if (rst_n && res_vld) begin
            if (exp_q.size() == 0) begin
                check("R8 unexpected", {res_hit, res_bank, res_line}, 18'h3FFFF);
            end else begin
                logic [17:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, {res_hit, res_bank, res_line}, e);
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs during and after reset
        check("R1 in reset", {res_vld, res_hit, res_bank, res_line}, 19'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", {res_vld, res_hit, res_bank, res_line}, 19'd0);
        // R2 R3 R4 R6 R7: boot map
        sweep();
        // R8: hold between strobes, one-cycle valid
        probe('h2E004, "R8");
        idle(4);
        check("R8 hold", {res_vld, res_hit, res_bank, res_line}, {1'b0, 1'b1, 2'd3, 15'h7801});
        // R9: remap write takes effect on next strobe
        write_map(1'b1);
        probe('h0, "R9 seg0 off");
        probe('h10000, "R9 seg1 on");
        idle(2);
        // R5 R3 R4 R6: remap map
        sweep();
        // R10: lock blocks writes
        @(negedge clk);
        init_done = 1'b1;
        write_map(1'b0);
        probe('h0, "R10 seg0 still off");
        probe('h17FFC, "R10 seg1 still on");
        idle(2);
        // R9: release lock and restore boot map
        @(negedge clk);
        init_done = 1'b0;
        write_map(1'b0);
        probe('h0, "R9 boot restored");
        probe('h10000, "R9 seg1 off");
        idle(2);
        sweep();
        check("R8 drained", 18'(exp_q.size()), 18'd0);
        finish_run();
    end
endmodule